// File: doc/BRIEF.md
# Reference Clock Presence Monitor

This block decides whether a slow reference clock (nominally 8 kHz) is present by counting its rising edges with the fast local clock. Time is split into back-to-back measurement windows. Each window lasts three nominal reference periods, timed as `RATIO * PERIODS` local cycles, where `RATIO` is the local-to-reference frequency ratio (4416 by default). At the end of every window the number of rising edges seen in it is compared with a threshold of two.

The outcome drives two plain control outputs. `ref_ok` says the reference is present. `free_run` is its complement and tells the downstream loop to hold its oscillator at the centre frequency instead of tracking the reference. The reference input is asynchronous. It passes through a synchronizer and an edge detector before any edge is counted. There is no data stream, so there is no valid/ready handshake. All pins are plain levels sampled on `clk`.

Top module: `ref_presence_mon`

## Requirements
- R1: From reset until the end of the first complete window, `ref_ok` is 0 and `free_run` is 1.
- R2: Windows follow each other with no gap. Each lasts exactly `RATIO * PERIODS` cycles of `clk`, counted from the first clock edge after `rst_n` is released.
- R3: Only low-to-high transitions of `ref_in` are counted. A level held high or low, and a falling transition, add nothing.
- R4: A window containing zero or one rising edge sets `ref_ok` to 0 and `free_run` to 1 at the window's end.
- R5: A window containing two or more rising edges sets `ref_ok` to 1 and `free_run` to 0. The edge count saturates at 4, so any larger number of edges still gives present.
- R6: `ref_ok` and `free_run` change only at a window boundary and hold their values in all other cycles.
- R7: The edge count is cleared at the start of each window, so edges from earlier windows never add to a later decision.
- R8: `free_run` is always the inverse of `ref_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local high-frequency clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference clock input |
| ref_ok | output | 1 | 1 when the last complete window saw two or more rising edges |
| free_run | output | 1 | 1 when the oscillator should stay at its centre frequency |

## Verification
The bench drives per-window edge counts of zero, one, two, three, four and five. This separates the threshold side of R4 from the side of R5 and exercises saturation. It also places a one-edge window straight after a busy one, which exposes any count carried between windows. One window holds the input high for its whole length, so a level cannot be mistaken for a series of edges. Outputs are also sampled halfway through each window, which catches an update that is not confined to window boundaries. Random windows are then mixed in.

// File: rtl/ref_mon_pkg.sv
package ref_mon_pkg;
  typedef enum logic {
    REF_LOST    = 1'b0,
    REF_PRESENT = 1'b1
  } ref_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R3
endmodule

// File: rtl/ref_window_timer.sv
module ref_window_timer #(
  parameter int WIN = 13248,
  localparam int TW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  logic [TW-1:0] tick_q;
  localparam logic [TW-1:0] LAST = TW'(WIN - 1);

  assign win_end = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       tick_q <= '0;
    else if (win_end) tick_q <= '0;
    else              tick_q <= tick_q + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST); // R2
  AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> tick_q == '0); // R2
endmodule

// File: rtl/ref_edge_judge.sv
module ref_edge_judge
  import ref_mon_pkg::*;
#(
  parameter int THRESH = 2,
  parameter int SAT    = 4,
  localparam int CW = $clog2(SAT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_pulse,
  input  logic       win_end,
  output ref_state_e state
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] THR_V = CW'(THRESH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q;
    if (rise_pulse && cnt_q != SAT_V) cnt_inc = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      state <= REF_LOST;
    end else if (win_end) begin
      cnt_q <= '0;
      state <= (cnt_inc >= THR_V) ? REF_PRESENT : REF_LOST;
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_V); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cnt_q == '0); // R7
  AST_HOLD_MIDWIN: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(state)); // R6
endmodule

// File: rtl/ref_presence_mon.sv
module ref_presence_mon
  import ref_mon_pkg::*;
#(
  parameter int RATIO       = 4416,
  parameter int PERIODS     = 3,
  parameter int THRESH      = 2,
  parameter int SAT         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WIN = RATIO * PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_ok,
  output logic free_run
);
  logic       rise_pulse;
  logic       win_end;
  ref_state_e state;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise_pulse(rise_pulse)
  );

  ref_window_timer #(.WIN(WIN)) timer_i (
    .clk(clk), .rst_n(rst_n), .win_end(win_end)
  );

  ref_edge_judge #(.THRESH(THRESH), .SAT(SAT)) judge_i (
    .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse),
    .win_end(win_end), .state(state)
  );

  assign ref_ok   = (state == REF_PRESENT);
  assign free_run = (state == REF_LOST);

  AST_FREE_RUN_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    free_run != ref_ok); // R8
endmodule

// File: tb/ref_presence_mon_tb.sv
module ref_presence_mon_tb_top;
  localparam int RATIO = 40;
  localparam int PERIODS = 3;
  localparam int W = RATIO * PERIODS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic ref_ok, free_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit exp_ok = 1'b0;
  bit prev_lvl = 1'b0;

  always #10 clk = ~clk;

  ref_presence_mon #(.RATIO(RATIO), .PERIODS(PERIODS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .ref_ok(ref_ok), .free_run(free_run)
  );

  // mode 1: hold high all window; mode 0: n pulses at slots 10+20k, 8 wide
  function automatic bit slot_val(int mode, int n, int i);
    if (mode == 1) return 1'b1;
    for (int k = 0; k < n; k++)
      if (i >= 10 + 20*k && i < 18 + 20*k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int count_rises(int mode, int n, bit prev);
    int c = 0;
    bit p = prev;
    for (int i = 0; i < W; i++) begin
      bit v = slot_val(mode, n, i);
      if (v && !p) c++;
      p = v;
    end
    return c;
  endfunction

  task automatic check(string req, bit got_ok, bit got_fr, bit e);
    n_chk++;
    if (got_ok !== e || got_fr !== !e) begin
      n_bad++;
      $display("FAIL %s: ref_ok=%0b free_run=%0b expected ref_ok=%0b free_run=%0b",
               req, got_ok, got_fr, e, !e);
    end
  endtask

  task automatic run_window(int mode, int n, string req);
    int  edges = count_rises(mode, n, prev_lvl);
    bit  nxt   = (edges >= 2);
    for (int i = 0; i < W; i++) begin
      ref_in = slot_val(mode, n, i);
      @(negedge clk);
      if (i == W/2) check("R6 mid-window hold", ref_ok, free_run, exp_ok);
    end
    prev_lvl = slot_val(mode, n, W-1);
    exp_ok = nxt;
    check(req, ref_ok, free_run, exp_ok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (4) @(negedge clk);
    check("R1 reset state", ref_ok, free_run, 1'b0);
    rst_n = 1'b1;
    // first window: R1 still lost during it (mid check) and two edges
    run_window(0, 2, "R5 two edges present");
    run_window(0, 1, "R4 one edge lost / R7 cleared");
    run_window(0, 0, "R4 zero edges lost");
    run_window(0, 3, "R5 three edges present");
    run_window(1, 0, "R3 held high is one edge, lost");
    run_window(0, 2, "R3 falling not counted, two rises present");
    run_window(0, 5, "R5 saturated count present");
    run_window(0, 1, "R7 no carry after busy window");
    run_window(0, 4, "R5 four edges present");
    run_window(0, 0, "R2 back-to-back window lost");
    for (int k = 0; k < 24; k++) begin
      int r = $urandom_range(0, 6);
      if (r == 6) run_window(1, 0, "R3 random hold");
      else        run_window(0, r, "R4/R5 random window");
    end
    check("R8 complement at end", ref_ok, free_run, exp_ok);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule